// File: doc/BRIEF.md
# Stack Call Return Interrupt Sequencer

This block carries out the stack traffic of a 16-bit segmented processor core. The core hands it one command at a time: push or pop a general word, push or pop the flag word, call near or far, return near or far, or take a software interrupt of a given type. The sequencer then runs the byte transfers needed on a byte-wide memory port, one byte per clock, and updates the registers it owns: stack pointer, instruction pointer, code segment and flags.

Stack bytes are addressed as the stack segment (a 16-bit input, shifted left by four) plus the stack pointer, truncated to 20 bits. A software interrupt saves the flags and the return point, masks single-step and interrupt enable, and then fetches its new entry point from a 4-byte vector at type times four. A one-cycle done pulse marks the cycle in which every register already holds its final value.

Top module: `stk_seq`

## Requirements
- R1: After reset, sp_o is 0x2000, ip_o, cs_o, flags_o and pop_data_o are 0, and busy_o, done_o and mem_we_o are low.
- R2: A word push writes its low byte at SS*16 + SP - 2 and its high byte at SS*16 + SP - 1, with the 20-bit address wrapping, and leaves SP lowered by 2.
- R3: A pop reads the low byte at SS*16 + SP and the high byte one address above, loads the word into pop_data_o, raises SP by 2, and leaves flags unchanged, as do push and flag push.
- R4: A flag push stores the whole flag word; a flag pop loads all 16 flag bits from the stack.
- R5: A near call pushes only IP, then loads IP from tgt_ip_i with CS kept; a far call pushes CS and then IP, then loads CS and IP from tgt_cs_i and tgt_ip_i.
- R6: A near return pops one word into IP; a far return pops IP first and CS second.
- R7: A software interrupt pushes the flags, clears flag bit 8 (single-step) and bit 9 (interrupt enable), pushes CS, pushes IP, then loads IP from the word at byte address type*4 and CS from the word at type*4 + 2; the type is 8 bits, 0 to 255.
- R8: Each byte transfer takes one cycle, so busy_o is high for exactly twice the number of words moved; done_o is a single-cycle pulse in the cycle after the last transfer, with all registers final.
- R9: cmd_i codes are 0 push, 1 pop, 2 flag push, 3 flag pop, 4 near call, 5 far call, 6 near return, 7 far return, 8 software interrupt; a command is taken only when busy_o is low, and codes 9 to 15 are ignored.
- R10: mem_we_o is high only in push byte cycles, and SP only ever changes by exactly 2.

Top module port list:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command strobe, sampled while idle |
| cmd_i | input | 4 | Command code |
| opnd_i | input | 16 | Word to push for a general push |
| tgt_cs_i | input | 16 | Target code segment for a far call |
| tgt_ip_i | input | 16 | Target instruction pointer for a call |
| int_type_i | input | 8 | Software interrupt type |
| ss_i | input | 16 | Stack segment, sampled with the command |
| busy_o | output | 1 | A command is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| pop_data_o | output | 16 | Word taken by the last general pop |
| sp_o | output | 16 | Stack pointer |
| ip_o | output | 16 | Instruction pointer |
| cs_o | output | 16 | Code segment |
| flags_o | output | 16 | Flag word |
| mem_addr_o | output | 20 | Byte address |
| mem_wdata_o | output | 8 | Byte to write |
| mem_we_o | output | 1 | Byte write enable |
| mem_rdata_i | input | 8 | Byte read, valid within the access cycle |

## Verification
The assertions watch, on every cycle, that SP moves only in steps of two, that registers hold still while idle, that done is a lone pulse, that an interrupt always finishes with single-step and interrupt enable cleared, and that legal and illegal codes start or fail to start a sequence. Only the bench scenarios can show the byte order on the stack, the push order of a far call or interrupt matched by the pop order of a far return, the vector lookup at type*4, the 20-bit address wrap, and the exact busy and write counts per command.

// File: rtl/stk_pkg.sv
package stk_pkg;

  typedef enum logic [3:0] {
    C_PUSH  = 4'd0,
    C_POP   = 4'd1,
    C_PUSHF = 4'd2,
    C_POPF  = 4'd3,
    C_CALLN = 4'd4,
    C_CALLF = 4'd5,
    C_RETN  = 4'd6,
    C_RETF  = 4'd7,
    C_INT   = 4'd8
  } cmd_e;

  typedef enum logic [1:0] {
    WK_PUSH,
    WK_POP,
    WK_VEC
  } wkind_e;

  // source of a pushed word, or destination of a read word
  typedef enum logic [1:0] {
    SEL_OPND,
    SEL_FLAGS,
    SEL_CS,
    SEL_IP
  } wsel_e;

  typedef struct packed {
    wkind_e kind;
    wsel_e  sel;
    logic   last;
  } wstep_t;

  localparam int TF_BIT = 8;
  localparam int IF_BIT = 9;

  function automatic logic cmd_known(logic [3:0] c);
    return c <= 4'd8;
  endfunction

endpackage

// File: rtl/stk_plan.sv
module stk_plan
  import stk_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  cmd_e             cmd_i,
  input  logic [IDX_W-1:0] widx_i,
  output wstep_t           step_o
);

  always_comb begin
    step_o = '{kind: WK_PUSH, sel: SEL_OPND, last: 1'b1};
    case (cmd_i)
      C_PUSH:  step_o = '{kind: WK_PUSH, sel: SEL_OPND,  last: 1'b1};
      C_PUSHF: step_o = '{kind: WK_PUSH, sel: SEL_FLAGS, last: 1'b1};
      C_POP:   step_o = '{kind: WK_POP,  sel: SEL_OPND,  last: 1'b1};
      C_POPF:  step_o = '{kind: WK_POP,  sel: SEL_FLAGS, last: 1'b1};
      C_CALLN: step_o = '{kind: WK_PUSH, sel: SEL_IP,    last: 1'b1};
      C_RETN:  step_o = '{kind: WK_POP,  sel: SEL_IP,    last: 1'b1};
      C_CALLF: begin
        if (widx_i == IDX_W'(0)) step_o = '{kind: WK_PUSH, sel: SEL_CS, last: 1'b0};
        else                     step_o = '{kind: WK_PUSH, sel: SEL_IP, last: 1'b1};
      end
      C_RETF: begin
        if (widx_i == IDX_W'(0)) step_o = '{kind: WK_POP, sel: SEL_IP, last: 1'b0};
        else                     step_o = '{kind: WK_POP, sel: SEL_CS, last: 1'b1};
      end
      C_INT: begin
        case (widx_i)
          IDX_W'(0): step_o = '{kind: WK_PUSH, sel: SEL_FLAGS, last: 1'b0};
          IDX_W'(1): step_o = '{kind: WK_PUSH, sel: SEL_CS,    last: 1'b0};
          IDX_W'(2): step_o = '{kind: WK_PUSH, sel: SEL_IP,    last: 1'b0};
          IDX_W'(3): step_o = '{kind: WK_VEC,  sel: SEL_IP,    last: 1'b0};
          default:   step_o = '{kind: WK_VEC,  sel: SEL_CS,    last: 1'b1};
        endcase
      end
      default: step_o = '{kind: WK_PUSH, sel: SEL_OPND, last: 1'b1};
    endcase
  end

endmodule

// File: rtl/stk_agu.sv
module stk_agu
  import stk_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int SEG_SHIFT = 4,
  parameter int TYPE_W    = 8,
  parameter int BYTES     = 2,
  parameter int BSEL_W    = 1,
  parameter int AW        = WORD_W + SEG_SHIFT
) (
  input  wkind_e            kind_i,
  input  wsel_e             sel_i,
  input  logic [WORD_W-1:0] seg_i,
  input  logic [WORD_W-1:0] sp_i,
  input  logic [TYPE_W-1:0] vtype_i,
  input  logic [BSEL_W-1:0] bsel_i,
  output logic [AW-1:0]     addr_o
);

  localparam int VEC_SH = $clog2(2 * BYTES);

  logic [WORD_W-1:0] off;
  logic [AW-1:0]     seg_base;
  logic [AW-1:0]     vec_base;

  always_comb begin
    seg_base = {seg_i, {SEG_SHIFT{1'b0}}};
    if (kind_i == WK_PUSH) off = sp_i - WORD_W'(BYTES) + WORD_W'(bsel_i);
    else                   off = sp_i + WORD_W'(bsel_i);
    vec_base = AW'(vtype_i) << VEC_SH;
    if (sel_i == SEL_CS) vec_base = vec_base + AW'(BYTES);
    if (kind_i == WK_VEC) addr_o = vec_base + AW'(bsel_i);
    else                  addr_o = seg_base + AW'(off);
  end

endmodule

// File: rtl/stk_seq.sv
module stk_seq
  import stk_pkg::*;
#(
  parameter int              WORD_W    = 16,
  parameter int              BYTE_W    = 8,
  parameter int              SEG_SHIFT = 4,
  parameter int              TYPE_W    = 8,
  parameter int              MAX_WORDS = 5,
  parameter logic [WORD_W-1:0] SP_RST  = 16'h2000,
  parameter logic [WORD_W-1:0] IP_RST  = 16'h0000,
  parameter logic [WORD_W-1:0] CS_RST  = 16'h0000,
  parameter logic [WORD_W-1:0] FL_RST  = 16'h0000,
  localparam int             AW        = WORD_W + SEG_SHIFT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [3:0]        cmd_i,
  input  logic [WORD_W-1:0] opnd_i,
  input  logic [WORD_W-1:0] tgt_cs_i,
  input  logic [WORD_W-1:0] tgt_ip_i,
  input  logic [TYPE_W-1:0] int_type_i,
  input  logic [WORD_W-1:0] ss_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [WORD_W-1:0] pop_data_o,
  output logic [WORD_W-1:0] sp_o,
  output logic [WORD_W-1:0] ip_o,
  output logic [WORD_W-1:0] cs_o,
  output logic [WORD_W-1:0] flags_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [BYTE_W-1:0] mem_wdata_o,
  output logic              mem_we_o,
  input  logic [BYTE_W-1:0] mem_rdata_i
);

  localparam int BYTES  = WORD_W / BYTE_W;
  localparam int BSEL_W = (BYTES > 1) ? $clog2(BYTES) : 1;
  localparam int IDX_W  = (MAX_WORDS > 1) ? $clog2(MAX_WORDS) : 1;

  logic              run_q, done_q;
  cmd_e              cmd_q;
  logic [WORD_W-1:0] opnd_q, tcs_q, tip_q, ss_q;
  logic [TYPE_W-1:0] type_q;
  logic [IDX_W-1:0]  widx_q;
  logic [BSEL_W-1:0] bsel_q;
  logic [WORD_W-1:0] rd_q, rd_next;
  logic [WORD_W-1:0] sp_q, ip_q, cs_q, flags_q, pop_q;
  logic [WORD_W-1:0] src_w;
  logic              accept, bsel_last;
  wstep_t            step;

  stk_plan #(.IDX_W(IDX_W)) u_plan (
    .cmd_i  (cmd_q),
    .widx_i (widx_q),
    .step_o (step)
  );

  stk_agu #(
    .WORD_W   (WORD_W),
    .SEG_SHIFT(SEG_SHIFT),
    .TYPE_W   (TYPE_W),
    .BYTES    (BYTES),
    .BSEL_W   (BSEL_W),
    .AW       (AW)
  ) u_agu (
    .kind_i  (step.kind),
    .sel_i   (step.sel),
    .seg_i   (ss_q),
    .sp_i    (sp_q),
    .vtype_i (type_q),
    .bsel_i  (bsel_q),
    .addr_o  (mem_addr_o)
  );

  assign accept    = !run_q && cmd_valid_i && cmd_known(cmd_i);
  assign bsel_last = (bsel_q == BSEL_W'(BYTES - 1));
  assign rd_next   = {mem_rdata_i, rd_q[WORD_W-1:BYTE_W]};

  always_comb begin
    case (step.sel)
      SEL_FLAGS: src_w = flags_q;
      SEL_CS:    src_w = cs_q;
      SEL_IP:    src_w = ip_q;
      default:   src_w = opnd_q;
    endcase
  end

  assign mem_wdata_o = src_w[bsel_q*BYTE_W +: BYTE_W];
  assign mem_we_o    = run_q && (step.kind == WK_PUSH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      done_q  <= 1'b0;
      cmd_q   <= C_PUSH;
      opnd_q  <= '0;
      tcs_q   <= '0;
      tip_q   <= '0;
      ss_q    <= '0;
      type_q  <= '0;
      widx_q  <= '0;
      bsel_q  <= '0;
      rd_q    <= '0;
      sp_q    <= SP_RST;
      ip_q    <= IP_RST;
      cs_q    <= CS_RST;
      flags_q <= FL_RST;
      pop_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        run_q  <= 1'b1;
        cmd_q  <= cmd_e'(cmd_i);
        opnd_q <= opnd_i;
        tcs_q  <= tgt_cs_i;
        tip_q  <= tgt_ip_i;
        ss_q   <= ss_i;
        type_q <= int_type_i;
        widx_q <= '0;
        bsel_q <= '0;
      end else if (run_q) begin
        if (step.kind != WK_PUSH) rd_q <= rd_next;
        if (!bsel_last) begin
          bsel_q <= bsel_q + BSEL_W'(1);
        end else begin
          bsel_q <= '0;
          if (step.kind == WK_PUSH) sp_q <= sp_q - WORD_W'(BYTES);
          if (step.kind == WK_POP)  sp_q <= sp_q + WORD_W'(BYTES);
          if (step.kind != WK_PUSH) begin
            case (step.sel)
              SEL_FLAGS: flags_q <= rd_next;
              SEL_CS:    cs_q    <= rd_next;
              SEL_IP:    ip_q    <= rd_next;
              default:   pop_q   <= rd_next;
            endcase
          end
          // mask single-step and interrupt enable once the old flags are saved
          if (cmd_q == C_INT && widx_q == '0) begin
            flags_q[TF_BIT] <= 1'b0;
            flags_q[IF_BIT] <= 1'b0;
          end
          if (step.last) begin
            run_q  <= 1'b0;
            done_q <= 1'b1;
            widx_q <= '0;
            if (cmd_q == C_CALLN || cmd_q == C_CALLF) ip_q <= tip_q;
            if (cmd_q == C_CALLF) cs_q <= tcs_q;
          end else begin
            widx_q <= widx_q + IDX_W'(1);
          end
        end
      end
    end
  end

  assign busy_o     = run_q;
  assign done_o     = done_q;
  assign pop_data_o = pop_q;
  assign sp_o       = sp_q;
  assign ip_o       = ip_q;
  assign cs_o       = cs_q;
  assign flags_o    = flags_q;

  // R10
  sp_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sp_q != $past(sp_q)) |->
      (sp_q == $past(sp_q) - WORD_W'(BYTES) || sp_q == $past(sp_q) + WORD_W'(BYTES)));

  // R8
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> ($stable(sp_q) && $stable(ip_q) && $stable(cs_q) && $stable(flags_q)));

  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R7
  int_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && cmd_q == C_INT) |-> (!flags_q[TF_BIT] && !flags_q[IF_BIT]));

  // R9
  cmd_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && cmd_valid_i && cmd_i <= 4'd8) |=> busy_o);

  // R9
  cmd_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && cmd_valid_i && cmd_i > 4'd8) |=> !busy_o);

endmodule

// File: tb/stk_seq_bench.sv
module stk_seq_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid;
  logic [3:0]  cmd;
  logic [15:0] opnd, tcs, tip, ss;
  logic [7:0]  ityp;
  logic        busy, done, we;
  logic [15:0] pop_data, sp, ip, cs, flags;
  logic [19:0] addr;
  logic [7:0]  wdata, rdata;

  int n_tests = 0;
  int n_fail  = 0;

  logic [7:0] mem [logic [19:0]];

  always #(CLK_PERIOD/2) clk = ~clk;

  stk_seq u_stk_seq (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .cmd_valid_i (cmd_valid),
    .cmd_i       (cmd),
    .opnd_i      (opnd),
    .tgt_cs_i    (tcs),
    .tgt_ip_i    (tip),
    .int_type_i  (ityp),
    .ss_i        (ss),
    .busy_o      (busy),
    .done_o      (done),
    .pop_data_o  (pop_data),
    .sp_o        (sp),
    .ip_o        (ip),
    .cs_o        (cs),
    .flags_o     (flags),
    .mem_addr_o  (addr),
    .mem_wdata_o (wdata),
    .mem_we_o    (we),
    .mem_rdata_i (rdata)
  );

  function automatic logic [7:0] peek(logic [19:0] a);
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction

  always @(posedge clk) if (we) mem[addr] = wdata;
  always @(negedge clk) rdata = peek(addr);

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic wait_done(output int busy_n, output int wr_n);
    busy_n = 0;
    wr_n   = 0;
    for (int k = 0; k < 64; k++) begin
      if (done) break;
      if (busy) busy_n++;
      if (we) wr_n++;
      @(negedge clk);
    end
    if (!done) chk("R8 done never seen", 32'd0, 32'd1);
  endtask

  task automatic run(input logic [3:0] c, input logic [15:0] o, input logic [15:0] cs_t,
                     input logic [15:0] ip_t, input logic [7:0] t,
                     output int busy_n, output int wr_n);
    @(negedge clk);
    cmd_valid = 1'b1; cmd = c; opnd = o; tcs = cs_t; tip = ip_t; ityp = t;
    @(negedge clk);
    cmd_valid = 1'b0;
    wait_done(busy_n, wr_n);
  endtask

  function automatic string tag(logic [3:0] c);
    case (c)
      4'd0:       return "R2";
      4'd1:       return "R3";
      4'd2, 4'd3: return "R4";
      4'd4, 4'd5: return "R5";
      4'd6, 4'd7: return "R6";
      default:    return "R7";
    endcase
  endfunction

  typedef struct packed {
    logic [3:0]  c;
    logic [15:0] o, cs_t, ip_t;
    logic [7:0]  t;
    logic [15:0] e_sp, e_ip, e_cs, e_fl, e_pd;
    logic [3:0]  words, push_words;
  } row_t;

  localparam int NROW = 12;
  localparam row_t TBL [NROW] = '{
    '{4'd0, 16'h1334, 16'h0000, 16'h0000, 8'h00, 16'h1FFE, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 4'd1, 4'd1},
    '{4'd3, 16'h0000, 16'h0000, 16'h0000, 8'h00, 16'h2000, 16'h0000, 16'h0000, 16'h1334, 16'h0000, 4'd1, 4'd0},
    '{4'd2, 16'h0000, 16'h0000, 16'h0000, 8'h00, 16'h1FFE, 16'h0000, 16'h0000, 16'h1334, 16'h0000, 4'd1, 4'd1},
    '{4'd1, 16'h0000, 16'h0000, 16'h0000, 8'h00, 16'h2000, 16'h0000, 16'h0000, 16'h1334, 16'h1334, 4'd1, 4'd0},
    '{4'd5, 16'h0000, 16'h1234, 16'h2348, 8'h00, 16'h1FFC, 16'h2348, 16'h1234, 16'h1334, 16'h1334, 4'd2, 4'd2},
    '{4'd5, 16'h0000, 16'h3456, 16'h0120, 8'h00, 16'h1FF8, 16'h0120, 16'h3456, 16'h1334, 16'h1334, 4'd2, 4'd2},
    '{4'd4, 16'h0000, 16'h0000, 16'h0500, 8'h00, 16'h1FF6, 16'h0500, 16'h3456, 16'h1334, 16'h1334, 4'd1, 4'd1},
    '{4'd6, 16'h0000, 16'h0000, 16'h0000, 8'h00, 16'h1FF8, 16'h0120, 16'h3456, 16'h1334, 16'h1334, 4'd1, 4'd0},
    '{4'd7, 16'h0000, 16'h0000, 16'h0000, 8'h00, 16'h1FFC, 16'h2348, 16'h1234, 16'h1334, 16'h1334, 4'd2, 4'd0},
    '{4'd8, 16'h0000, 16'h0000, 16'h0000, 8'h20, 16'h1FF6, 16'h2345, 16'h6000, 16'h1034, 16'h1334, 4'd5, 4'd3},
    '{4'd7, 16'h0000, 16'h0000, 16'h0000, 8'h00, 16'h1FFA, 16'h2348, 16'h1234, 16'h1034, 16'h1334, 4'd2, 4'd0},
    '{4'd3, 16'h0000, 16'h0000, 16'h0000, 8'h00, 16'h1FFC, 16'h2348, 16'h1234, 16'h1334, 16'h1334, 4'd1, 4'd0}
  };

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R8 watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int bn, wn;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd = '0; opnd = '0; tcs = '0; tip = '0;
    ityp = '0; ss = 16'h1000;
    // vector for type 0x20: IP 0x2345, CS 0x6000
    mem[20'h00080] = 8'h45; mem[20'h00081] = 8'h23;
    mem[20'h00082] = 8'h00; mem[20'h00083] = 8'h60;
    // vector for type 0xFF: IP 0xBEEF, CS 0xDEAD
    mem[20'h003FC] = 8'hEF; mem[20'h003FD] = 8'hBE;
    mem[20'h003FE] = 8'hAD; mem[20'h003FF] = 8'hDE;

    repeat (3) @(negedge clk);
    chk("R1 sp", sp, 16'h2000);
    chk("R1 ip", ip, 16'h0000);
    chk("R1 cs", cs, 16'h0000);
    chk("R1 flags", flags, 16'h0000);
    chk("R1 pop_data", pop_data, 16'h0000);
    chk("R1 busy/done/we", {busy, done, we}, 3'b000);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 sp after release", sp, 16'h2000);

    for (int i = 0; i < NROW; i++) begin
      run(TBL[i].c, TBL[i].o, TBL[i].cs_t, TBL[i].ip_t, TBL[i].t, bn, wn);
      chk({tag(TBL[i].c), " sp"}, sp, TBL[i].e_sp);
      chk({tag(TBL[i].c), " ip"}, ip, TBL[i].e_ip);
      chk({tag(TBL[i].c), " cs"}, cs, TBL[i].e_cs);
      chk({tag(TBL[i].c), " flags"}, flags, TBL[i].e_fl);
      chk({tag(TBL[i].c), " pop_data"}, pop_data, TBL[i].e_pd);
      chk("R8 busy cycles", bn, 2 * int'(TBL[i].words));
      chk("R10 write cycles", wn, 2 * int'(TBL[i].push_words));
    end

    // R7 interrupt frame: flags at 1FFA, CS at 1FF8, IP at 1FF6
    chk("R7 frame flags lo", peek(20'h11FFA), 8'h34);
    chk("R7 frame flags hi", peek(20'h11FFB), 8'h13);
    chk("R7 frame cs lo", peek(20'h11FF8), 8'h34);
    chk("R7 frame cs hi", peek(20'h11FF9), 8'h12);
    chk("R7 frame ip lo", peek(20'h11FF6), 8'h48);
    chk("R7 frame ip hi", peek(20'h11FF7), 8'h23);

    // second reset
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R1 sp in reset", sp, 16'h2000);
    chk("R1 flags in reset", flags, 16'h0000);
    rst_n = 1'b1;

    // R2 byte placement
    run(4'd0, 16'h1234, 16'h0, 16'h0, 8'h0, bn, wn);
    chk("R2 low byte", peek(20'h11FFE), 8'h34);
    chk("R2 high byte", peek(20'h11FFF), 8'h12);
    chk("R2 sp", sp, 16'h1FFE);

    // R2 20-bit address wrap
    ss = 16'hFFFF;
    run(4'd0, 16'hABCD, 16'h0, 16'h0, 8'h0, bn, wn);
    chk("R2 wrap low byte", peek(20'h01FEC), 8'hCD);
    chk("R2 wrap high byte", peek(20'h01FED), 8'hAB);
    chk("R2 wrap sp", sp, 16'h1FFC);
    ss = 16'h1000;

    // R7 highest interrupt type
    run(4'd8, 16'h0, 16'h0, 16'h0, 8'hFF, bn, wn);
    chk("R7 type FF ip", ip, 16'hBEEF);
    chk("R7 type FF cs", cs, 16'hDEAD);
    chk("R7 type FF sp", sp, 16'h1FF6);
    chk("R8 type FF busy cycles", bn, 10);

    // R9 unknown code ignored
    @(negedge clk); cmd_valid = 1'b1; cmd = 4'd12;
    @(negedge clk); cmd_valid = 1'b0;
    chk("R9 unknown code busy", busy, 1'b0);
    repeat (3) @(negedge clk);
    chk("R9 unknown code done", done, 1'b0);
    chk("R9 unknown code sp", sp, 16'h1FF6);

    // R9 command while busy ignored
    @(negedge clk); cmd_valid = 1'b1; cmd = 4'd0; opnd = 16'h5555;
    @(negedge clk); cmd = 4'd1;
    @(negedge clk); cmd_valid = 1'b0;
    wait_done(bn, wn);
    chk("R9 busy ignore sp", sp, 16'h1FF4);
    chk("R9 busy ignore byte", peek(20'h11FF4), 8'h55);
    chk("R9 busy ignore pop_data", pop_data, 16'h0000);
    @(negedge clk);
    chk("R8 done single pulse", done, 1'b0);
    chk("R9 idle after ignore", busy, 1'b0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule